// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter

This block decides which of several bus masters may use one slave port of a multi-master crossbar. Each master raises a request line. The arbiter answers with a registered one-hot grant and the index of the master that holds it. A granted master keeps the slave until it strobes transaction-done. The grant is then released, and the next owner is picked on the following idle cycle.

Two ordering modes are selected by one input. In round-robin mode, all masters have equal standing. The search for a winner starts at the master just after the most recently granted one. In fixed mode, the lowest-numbered requester wins. Any master may also be boosted for a while. Boosted requesters beat all others, and if several are boosted, the active mode settles the tie among them. Address decoding, data steering and bus timing live elsewhere in the crossbar.

Top module: `xbar_port_arbiter`

## Requirements
- R1: After synchronous reset, `grant` is 0 and `grant_id` is N_MASTERS-1 (3 with defaults).
- R2: `grant` is always all-zero or one-hot, with bit i standing for master i.
- R3: While `grant` is non-zero and `xfer_done` is low, `grant` keeps its value on the next clock edge, whatever `req`, `boost` or `prio_fixed` do.
- R4: A clock edge with `grant` non-zero and `xfer_done` high clears `grant` to 0. No master is granted on that same edge, even if requests are pending.
- R5: With `prio_fixed`=0, an idle edge with pending requests grants the first requesting master found by counting upward (wrapping) from the master after `grant_id`. After reset this makes master 0 the first winner.
- R6: With `prio_fixed`=1, an idle edge with pending requests grants the lowest-numbered requesting master.
- R7: If at least one master has both `req` and `boost` set, only such masters can win. A `boost` bit on a non-requesting master has no effect.
- R8: When several requesting masters are boosted, the winner among them is chosen by the rule of the current mode (R5 or R6).
- R9: When idle with no requests, `grant` stays 0 and `grant_id` keeps the last granted index.
- R10: `xfer_done` while idle has no effect on `grant` or `grant_id`.
- R11: While `grant` is non-zero, `grant_id` equals the index of its set bit.
- R12: A master becomes granted only if its `req` was high in the cycle of the arbitration edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_fixed | input | 1 | 1 = fixed priority by index, 0 = round-robin |
| req | input | N_MASTERS | Per-master request |
| boost | input | N_MASTERS | Per-master temporary priority raise |
| xfer_done | input | 1 | Current owner's transaction finishes this cycle |
| grant | output | N_MASTERS | One-hot registered grant |
| grant_id | output | $clog2(N_MASTERS) | Index of current or last granted master |

## Verification
The bench targets the round-robin wrap. A requester below the pointer must be found after the search runs past the top index. A pointer that failed to wrap, or that moved on a failed search, would pick the wrong master or none. Requests and boosts are changed mid-transaction, and transaction-done is pulsed while pending requests exist, so that a design that re-arbitrated early, or handed over without the idle cycle, would show a changed or immediately refilled grant. Boost is also applied to non-requesting masters and to several masters at once in both modes, which exposes a filter that let a lone boost blank the request set or ignored the mode among boosted masters.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;
  typedef enum logic {
    ARB_ROUND_ROBIN = 1'b0,
    ARB_FIXED       = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_elev_filter.sv
module arb_elev_filter #(
  parameter int N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] boost,
  output logic [N_MASTERS-1:0] cand
);
  logic [N_MASTERS-1:0] boosted;

  // per-master qualification of boost by request
  for (genvar g = 0; g < N_MASTERS; g++) begin : g_qual
    assign boosted[g] = req[g] & boost[g];
  end

  // boosted requesters, when present, hide the rest
  assign cand = (|boosted) ? boosted : req;
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int N_MASTERS = 4,
  localparam int IDW = $clog2(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] cand,
  output logic [IDW-1:0]       pick
);
  always_comb begin
    pick = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (cand[i]) pick = IDW'(i);
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_MASTERS = 4,
  localparam int IDW = $clog2(N_MASTERS)
) (
  input  logic [N_MASTERS-1:0] cand,
  input  logic [IDW-1:0]       last,
  output logic [IDW-1:0]       pick
);
  always_comb begin
    pick = last;
    // scan farthest offset first so the nearest hit is kept
    for (int k = N_MASTERS; k >= 1; k--) begin
      int unsigned s;
      s = (int'(unsigned'(last)) + k) % N_MASTERS;
      if (cand[s[IDW-1:0]]) pick = s[IDW-1:0];
    end
  end
endmodule

// File: rtl/xbar_port_arbiter.sv
module xbar_port_arbiter #(
  parameter int N_MASTERS = 4,
  localparam int IDW = $clog2(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 prio_fixed,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] boost,
  input  logic                 xfer_done,
  output logic [N_MASTERS-1:0] grant,
  output logic [IDW-1:0]       grant_id
);
  import xbar_arb_pkg::*;

  arb_mode_e            mode;
  logic [N_MASTERS-1:0] cand;
  logic [IDW-1:0]       pick_fixed;
  logic [IDW-1:0]       pick_rr;
  logic [IDW-1:0]       pick;
  logic [N_MASTERS-1:0] pick_vec;
  logic [N_MASTERS-1:0] grant_q;
  logic [IDW-1:0]       last_q;
  logic                 idle;

  assign mode = arb_mode_e'(prio_fixed);
  assign idle = ~(|grant_q);

  arb_elev_filter #(.N_MASTERS(N_MASTERS)) u_filter (
    .req   (req),
    .boost (boost),
    .cand  (cand)
  );

  arb_fixed_pick #(.N_MASTERS(N_MASTERS)) u_fixed (
    .cand (cand),
    .pick (pick_fixed)
  );

  arb_rr_pick #(.N_MASTERS(N_MASTERS)) u_rr (
    .cand (cand),
    .last (last_q),
    .pick (pick_rr)
  );

  assign pick = (mode == ARB_FIXED) ? pick_fixed : pick_rr;

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
    assign pick_vec[g] = (pick == IDW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= IDW'(N_MASTERS - 1);
    end else if (!idle) begin
      if (xfer_done) grant_q <= '0;
    end else if (|cand) begin
      grant_q <= pick_vec;
      last_q  <= pick;
    end
  end

  assign grant    = grant_q;
  assign grant_id = last_q;
endmodule

// File: rtl/xbar_port_arbiter_chk.sv
module xbar_port_arbiter_chk #(
  parameter int N_MASTERS = 4,
  localparam int IDW = $clog2(N_MASTERS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 prio_fixed,
  input logic [N_MASTERS-1:0] req,
  input logic [N_MASTERS-1:0] boost,
  input logic                 xfer_done,
  input logic [N_MASTERS-1:0] grant,
  input logic [IDW-1:0]       grant_id
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !xfer_done) |=> grant == $past(grant));

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && xfer_done) |=> grant == '0);

  assert_boost_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && (req & boost) != '0) |=> (grant & $past(req & boost)) != '0);

  assert_idle_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req == '0) |=> (grant == '0 && $stable(grant_id)));

  assert_id_match_R11: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> grant[grant_id]);

  assert_req_needed_R12: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req != '0) |=> (grant & $past(req)) != '0);
endmodule

bind xbar_port_arbiter xbar_port_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .prio_fixed (prio_fixed),
  .req        (req),
  .boost      (boost),
  .xfer_done  (xfer_done),
  .grant      (grant),
  .grant_id   (grant_id)
);

// File: tb/test_xbar_port_arbiter.sv
module test_xbar_port_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         prio_fixed = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] boost = '0;
  logic         xfer_done = 1'b0;
  logic [N-1:0] grant;
  logic [1:0]   grant_id;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  xbar_port_arbiter #(.N_MASTERS(N)) i_xbar_port_arbiter (
    .clk(clk), .rst(rst), .prio_fixed(prio_fixed), .req(req),
    .boost(boost), .xfer_done(xfer_done), .grant(grant), .grant_id(grant_id)
  );

  task automatic check(input logic [N-1:0] exp_g, input int exp_id, input string tag);
    checks++;
    if (grant !== exp_g || int'(grant_id) != exp_id) begin
      errors++;
      $display("FAIL %s: grant=%b id=%0d expected grant=%b id=%0d",
               tag, grant, grant_id, exp_g, exp_id);
    end
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] b,
                       input logic m, input logic d);
    @(negedge clk);
    req = r; boost = b; prio_fixed = m; xfer_done = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // grant one master, then release it with a done pulse
  task automatic win(input logic [N-1:0] r, input logic [N-1:0] b, input logic m,
                     input logic [N-1:0] exp_g, input int exp_id, input string tag);
    drive(r, b, m, 1'b0);
    tick();
    check(exp_g, exp_id, tag);
    drive(r, b, m, 1'b1);
    tick();
    check('0, exp_id, "R4 release");
    drive('0, '0, m, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check('0, 3, "R1 reset state");
  endtask

  task automatic t_hold();
    drive(4'b1111, '0, 1'b0, 1'b0);
    tick();
    check(4'b0001, 0, "R5 first winner after reset");
    for (int i = 0; i < 3; i++) begin
      tick();
      check(4'b0001, 0, "R3 hold");
    end
    drive(4'b1110, 4'b1000, 1'b1, 1'b0);
    tick();
    check(4'b0001, 0, "R3 hold across input change");
    drive(4'b1110, 4'b1000, 1'b0, 1'b1);
    tick();
    check('0, 0, "R4 no same-edge handover");
    drive('0, '0, 1'b0, 1'b0);
  endtask

  task automatic t_round_robin();
    win(4'b1111, '0, 1'b0, 4'b0010, 1, "R5 rotate to 1");
    win(4'b0001, '0, 1'b0, 4'b0001, 0, "R5 wrap to 0");
    win(4'b1100, '0, 1'b0, 4'b0100, 2, "R5 skip to 2");
    win(4'b1011, '0, 1'b0, 4'b1000, 3, "R5 next 3");
    win(4'b0011, '0, 1'b0, 4'b0001, 0, "R5 wrap from 3");
  endtask

  task automatic t_idle();
    drive('0, '0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      tick();
      check('0, 0, "R9 idle keeps id");
    end
    drive('0, '0, 1'b0, 1'b1);
    tick();
    check('0, 0, "R10 done while idle");
    win(4'b0100, '0, 1'b0, 4'b0100, 2, "R10 normal grant after idle done");
  endtask

  task automatic t_fixed();
    win(4'b1100, '0, 1'b1, 4'b0100, 2, "R6 lowest of 2,3");
    win(4'b1110, '0, 1'b1, 4'b0010, 1, "R6 lowest of 1..3");
    win(4'b1000, '0, 1'b1, 4'b1000, 3, "R6 single");
  endtask

  task automatic t_boost();
    win(4'b1111, 4'b1000, 1'b1, 4'b1000, 3, "R7 boost beats fixed order");
    win(4'b1111, 4'b1010, 1'b1, 4'b0010, 1, "R8 fixed among boosted");
    win(4'b1111, 4'b1010, 1'b0, 4'b1000, 3, "R8 round-robin among boosted");
    win(4'b0011, 4'b0100, 1'b0, 4'b0001, 0, "R7 boost on idle master ignored");
    win(4'b0110, 4'b0001, 1'b1, 4'b0010, 1, "R7 boost ignored fixed");
  endtask

  initial begin
    t_reset();
    t_hold();
    t_round_robin();
    t_idle();
    t_fixed();
    t_boost();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule